// File: doc/BRIEF.md
# Concurrent-Write Shared Register File

This block is a small shared register file for a group of processing elements that all run in lockstep. In every clock cycle each port may read one cell and write one cell. Reads come first and return the contents held before that cycle's writes. Any combinational work in the requesting logic happens next. The write phase is applied at the closing clock edge. Every port reaches every cell with the same single-cycle latency.

When two or more ports target the same cell with a write in one cycle, a runtime policy input decides the outcome. The policies are:

- **exclusive**: the collision is an error and the cell is left alone.
- **arbitrary**: a rotating pointer picks the winner.
- **common**: all writers must agree on the value.
- **priority**: the lowest-index or highest-index writer wins.
- **combining**: the cell receives the wrapped sum or the unsigned maximum of all colliding values.

Two flags report, in the same cycle as the request, whether a write collision occurred and whether the cycle broke the active policy's rules.

Top module: `cwrf_shared_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, every cell is cleared to zero and the arbitration pointer returns to port 0. With no requests, `collision_o` and `error_o` are low.
- R2: `rd_data_o` slice p (bits p*DW up to p*DW+DW-1) always shows the cell named by `rd_addr_i` slice p, with no clock delay. The value shown is the one held before the writes of that same cycle. A write becomes visible in the cycle after its edge.
- R3: A cell written by exactly one port stores that port's data under every policy code.
- R4: Policy code 0 (exclusive) treats two ports with `rd_en_i` set and the same read address as an error and raises `error_o`. Two ports writing one cell raise `collision_o` and `error_o`, and the cell is left unchanged. Codes 5 to 7 behave as code 0.
- R5: Policy code 1 (arbitrary) stores the value of the first writing port found by scanning upward from the pointer, wrapping past the top port. The pointer advances by one, modulo the port count, after every cycle that has at least one write collision under this code. It advances once per cycle however many cells collide, and it holds otherwise.
- R6: Policy code 2 (common) stores the shared value when all colliding writers agree, with `error_o` low. When the writers disagree it raises `error_o` and the cell keeps its previous contents.
- R7: Policy code 3 (priority) stores the value from the lowest-index colliding port when `prio_high_i` is 0, and from the highest-index colliding port when it is 1.
- R8: Policy code 4 (combining) with `comb_max_i` at 0 stores the sum of all colliding values, wrapped modulo 2^DW.
- R9: Policy code 4 with `comb_max_i` at 1 stores the largest colliding value, compared as unsigned.
- R10: `collision_o` is high exactly when some cell has two or more writers in the current cycle, under any policy. `error_o` is never high under codes 1, 3 or 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the write phase commits on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears the cells and the pointer |
| mode_i | input | 3 | Collision policy: 0 exclusive, 1 arbitrary, 2 common, 3 priority, 4 combining |
| prio_high_i | input | 1 | Priority policy: 1 means the highest-index port wins |
| comb_max_i | input | 1 | Combining policy: 0 means sum, 1 means maximum |
| rd_en_i | input | NPORTS | Per-port read request, used for exclusive read checking |
| rd_addr_i | input | NPORTS*AW | Per-port read address, port p at bits p*AW |
| rd_data_o | output | NPORTS*DW | Per-port read data, port p at bits p*DW |
| wr_en_i | input | NPORTS | Per-port write request |
| wr_addr_i | input | NPORTS*AW | Per-port write address, port p at bits p*AW |
| wr_data_i | input | NPORTS*DW | Per-port write data, port p at bits p*DW |
| collision_o | output | 1 | A cell has two or more writers this cycle |
| error_o | output | 1 | The cycle violates the rules of the selected policy |

## Verification
The hardest behaviour to reach from the ports is the arbitrary policy. Its result depends on a hidden pointer whose position is set by every earlier colliding cycle, including cycles that hit several cells at once and cycles where the pointer wraps. A second hard case is a common-policy disagreement that leaves a cell unchanged even though writes were requested.

The stimulus packs random addresses into a four-cell window so that collisions happen in most cycles. It draws write data from a narrow range so that agreeing and disagreeing groups both occur. It switches the policy every cycle, and the bench's own pointer and memory model follow the whole history. Directed sequences come first and walk the pointer through a wrap, the sum overflow and the extremes of the unsigned maximum.

// File: rtl/cwrf_pkg.sv
// Shared types for the concurrent-write shared register file.
// The collision policy codes are visible at the top-level mode_i port,
// so their numeric values are fixed here.
package cwrf_pkg;

    typedef enum logic [2:0] {
        POL_EXCL   = 3'd0,
        POL_ARB    = 3'd1,
        POL_COMMON = 3'd2,
        POL_PRIO   = 3'd3,
        POL_COMB   = 3'd4
    } policy_e;

endpackage

// File: rtl/cwrf_wr_decode.sv
// Write-target decoder.
// For each cell, produces a mask of the ports that write that cell in this
// cycle. Assumes addresses are below DEPTH; an address at or above DEPTH
// matches no cell.
module cwrf_wr_decode #(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 16,
    parameter int AW     = 4
) (
    input  logic [NPORTS-1:0]             wr_en_i,
    input  logic [NPORTS*AW-1:0]          wr_addr_i,
    output logic [DEPTH-1:0][NPORTS-1:0]  hit_o
);

    for (genvar c = 0; c < DEPTH; c++) begin : g_cell
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            // Port p targets cell c with a write.
            assign hit_o[c][p] = wr_en_i[p] && (wr_addr_i[p*AW +: AW] == AW'(c));
        end
    end

endmodule

// File: rtl/cwrf_rd_clash.sv
// Read-collision detector.
// Raises clash_o when any two enabled read ports share an address. The top
// level decides whether the selected policy treats this as an error.
module cwrf_rd_clash #(
    parameter int NPORTS = 4,
    parameter int AW     = 4
) (
    input  logic [NPORTS-1:0]    rd_en_i,
    input  logic [NPORTS*AW-1:0] rd_addr_i,
    output logic                 clash_o
);

    // Compare every unordered pair of enabled readers.
    always_comb begin
        clash_o = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            for (int j = i + 1; j < NPORTS; j++) begin
                if (rd_en_i[i] && rd_en_i[j] &&
                    (rd_addr_i[i*AW +: AW] == rd_addr_i[j*AW +: AW]))
                    clash_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cwrf_cell_resolve.sv
// Per-cell write resolver.
// Given the mask of ports writing this cell, decides whether the cell is
// written and with which value, under the selected collision policy. A single
// writer always succeeds. Unknown policy codes act as exclusive. Assumes the
// pointer is below NPORTS.
module cwrf_cell_resolve
    import cwrf_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DW     = 8,
    parameter int PW     = 2
) (
    input  logic [NPORTS-1:0]          hit_i,
    input  logic [NPORTS-1:0][DW-1:0]  data_i,
    input  policy_e                    policy_i,
    input  logic                       prio_high_i,
    input  logic                       comb_max_i,
    input  logic [PW-1:0]              ptr_i,
    output logic                       we_o,
    output logic [DW-1:0]              val_o,
    output logic                       multi_o,
    output logic                       err_o
);

    localparam int SW = PW + 1;

    logic [DW-1:0] v_low, v_high, v_sum, v_max, v_arb;
    logic          any_hit, agree, arb_found;
    logic [SW-1:0] writers;
    logic [SW-1:0] scan;

    // Gather the candidate results for each policy from the colliding writers.
    always_comb begin
        v_low   = '0;
        v_high  = '0;
        v_sum   = '0;
        v_max   = '0;
        any_hit = 1'b0;
        writers = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (hit_i[p]) begin
                if (!any_hit) v_low = data_i[p];
                any_hit = 1'b1;
                v_high  = data_i[p];
                v_sum   = v_sum + data_i[p];
                if (data_i[p] > v_max) v_max = data_i[p];
                if (writers != {SW{1'b1}}) writers = writers + 1'b1;
            end
        end
        agree = 1'b1;
        for (int p = 0; p < NPORTS; p++) begin
            if (hit_i[p] && (data_i[p] != v_low)) agree = 1'b0;
        end
    end

    // Rotating scan from the pointer to find the arbitrary-policy winner.
    always_comb begin
        v_arb     = '0;
        arb_found = 1'b0;
        scan      = '0;
        for (int k = 0; k < NPORTS; k++) begin
            scan = {1'b0, ptr_i} + SW'(k);
            if (scan >= SW'(NPORTS)) scan = scan - SW'(NPORTS);
            if (!arb_found && hit_i[scan[PW-1:0]]) begin
                v_arb     = data_i[scan[PW-1:0]];
                arb_found = 1'b1;
            end
        end
    end

    // Choose the write enable, value and flags for this cell.
    always_comb begin
        we_o    = 1'b0;
        val_o   = v_low;
        multi_o = (writers > SW'(1));
        err_o   = 1'b0;
        if (writers == SW'(1)) begin
            we_o = 1'b1;
        end else if (multi_o) begin
            case (policy_i)
                POL_ARB: begin
                    we_o  = 1'b1;
                    val_o = v_arb;
                end
                POL_COMMON: begin
                    we_o  = agree;
                    err_o = !agree;
                end
                POL_PRIO: begin
                    we_o  = 1'b1;
                    val_o = prio_high_i ? v_high : v_low;
                end
                POL_COMB: begin
                    we_o  = 1'b1;
                    val_o = comb_max_i ? v_max : v_sum;
                end
                default: begin
                    err_o = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/cwrf_shared_regfile.sv
// Concurrent-write shared register file, top level.
// NPORTS lockstep ports each read one cell, combinationally, before the edge
// and write one cell at the edge. Same-cell write collisions are resolved by
// the policy on mode_i. Assumes NPORTS >= 2 and that addresses are below
// DEPTH. Reset is synchronous and active low.
module cwrf_shared_regfile
    import cwrf_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 16,
    parameter int DW     = 8,
    parameter int AW     = $clog2(DEPTH),
    parameter int PW     = $clog2(NPORTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            mode_i,
    input  logic                  prio_high_i,
    input  logic                  comb_max_i,
    input  logic [NPORTS-1:0]     rd_en_i,
    input  logic [NPORTS*AW-1:0]  rd_addr_i,
    output logic [NPORTS*DW-1:0]  rd_data_o,
    input  logic [NPORTS-1:0]     wr_en_i,
    input  logic [NPORTS*AW-1:0]  wr_addr_i,
    input  logic [NPORTS*DW-1:0]  wr_data_i,
    output logic                  collision_o,
    output logic                  error_o
);

    policy_e                      policy;
    logic [DEPTH-1:0][DW-1:0]     mem_q;
    logic [PW-1:0]                ptr_q;
    logic [NPORTS-1:0][DW-1:0]    wdata;
    logic [DEPTH-1:0][NPORTS-1:0] hit;
    logic [DEPTH-1:0]             cell_we, cell_multi, cell_err;
    logic [DEPTH-1:0][DW-1:0]     cell_val;
    logic                         rd_clash, excl_rules;

    assign policy = policy_e'(mode_i);
    assign wdata  = wr_data_i;

    cwrf_wr_decode #(.NPORTS(NPORTS), .DEPTH(DEPTH), .AW(AW)) u_decode (
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .hit_o     (hit)
    );

    cwrf_rd_clash #(.NPORTS(NPORTS), .AW(AW)) u_rdclash (
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .clash_o   (rd_clash)
    );

    for (genvar c = 0; c < DEPTH; c++) begin : g_cell
        cwrf_cell_resolve #(.NPORTS(NPORTS), .DW(DW), .PW(PW)) u_resolve (
            .hit_i       (hit[c]),
            .data_i      (wdata),
            .policy_i    (policy),
            .prio_high_i (prio_high_i),
            .comb_max_i  (comb_max_i),
            .ptr_i       (ptr_q),
            .we_o        (cell_we[c]),
            .val_o       (cell_val[c]),
            .multi_o     (cell_multi[c]),
            .err_o       (cell_err[c])
        );

        // Write phase: commit the resolved value of this cell at the edge.
        always_ff @(posedge clk) begin
            if (!rst_n)          mem_q[c] <= '0;
            else if (cell_we[c]) mem_q[c] <= cell_val[c];
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_read
        // Read phase: return the pre-write contents of the addressed cell.
        assign rd_data_o[p*DW +: DW] = mem_q[rd_addr_i[p*AW +: AW]];
    end

    // Exclusive rules apply to code 0 and to every unassigned code.
    assign excl_rules = !(policy inside {POL_ARB, POL_COMMON, POL_PRIO, POL_COMB});

    // Aggregate the collision and violation flags for this cycle.
    assign collision_o = |cell_multi;
    assign error_o     = (|cell_err) | (excl_rules & rd_clash);

    // Advance the arbitrary-policy pointer once per colliding cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if ((policy == POL_ARB) && collision_o)
            ptr_q <= (ptr_q == PW'(NPORTS - 1)) ? '0 : ptr_q + 1'b1;
    end

endmodule

// File: rtl/cwrf_checker.sv
// Assertion checker for cwrf_shared_regfile, attached with bind below.
// Recomputes the collision conditions from the request ports and watches the
// cells and the arbitration pointer across clock edges.
module cwrf_checker #(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 16,
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int PW     = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [2:0]                mode_i,
    input logic [NPORTS-1:0]         rd_en_i,
    input logic [NPORTS*AW-1:0]      rd_addr_i,
    input logic [NPORTS-1:0]         wr_en_i,
    input logic [NPORTS*AW-1:0]      wr_addr_i,
    input logic [NPORTS*DW-1:0]      wr_data_i,
    input logic                      collision_o,
    input logic                      error_o,
    input logic [DEPTH-1:0][DW-1:0]  mem_q,
    input logic [PW-1:0]             ptr_q
);

    logic          wr_pair, rd_pair, solo0, solo0_q, seen_reset;
    logic [AW-1:0] a0_q;
    logic [DW-1:0] d0_q;

    // Pairwise search for shared write and shared read addresses.
    always_comb begin
        wr_pair = 1'b0;
        rd_pair = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            for (int j = i + 1; j < NPORTS; j++) begin
                if (wr_en_i[i] && wr_en_i[j] &&
                    wr_addr_i[i*AW +: AW] == wr_addr_i[j*AW +: AW]) wr_pair = 1'b1;
                if (rd_en_i[i] && rd_en_i[j] &&
                    rd_addr_i[i*AW +: AW] == rd_addr_i[j*AW +: AW]) rd_pair = 1'b1;
            end
        end
    end

    // Port 0 is the only writer of its cell this cycle.
    always_comb begin
        solo0 = wr_en_i[0];
        for (int p = 1; p < NPORTS; p++) begin
            if (wr_en_i[p] && wr_addr_i[p*AW +: AW] == wr_addr_i[AW-1:0]) solo0 = 1'b0;
        end
    end

    // Remember port 0's lone write so the following cycle can check it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            solo0_q    <= 1'b0;
            a0_q       <= '0;
            d0_q       <= '0;
            seen_reset <= 1'b1;
        end else begin
            solo0_q <= solo0;
            a0_q    <= wr_addr_i[AW-1:0];
            d0_q    <= wr_data_i[DW-1:0];
        end
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_reset && !$past(rst_n)) |-> (mem_q == '0 && ptr_q == '0));

    p_solo_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        solo0_q |-> (mem_q[a0_q] == d0_q));

    p_excl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0 && rd_pair) |-> error_o);

    p_excl_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0 && wr_pair) |-> error_o);

    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd1 && collision_o) |=>
        (ptr_q == (($past(ptr_q) == PW'(NPORTS - 1)) ? '0 : $past(ptr_q) + 1'b1)));

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_i == 3'd1 && collision_o) |=> $stable(ptr_q));

    p_collision_r10: assert property (@(posedge clk) disable iff (!rst_n)
        collision_o == wr_pair);

    p_err_scope_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd1 || mode_i == 3'd3 || mode_i == 3'd4) |-> !error_o);

endmodule

bind cwrf_shared_regfile cwrf_checker #(
    .NPORTS(NPORTS), .DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .collision_o (collision_o),
    .error_o     (error_o),
    .mem_q       (mem_q),
    .ptr_q       (ptr_q)
);

// File: tb/cwrf_shared_regfile_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a bench-side memory and pointer model.
module cwrf_shared_regfile_test;

    localparam int N     = 4;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [2:0]      mode;
    logic            prio_high, comb_max;
    logic [N-1:0]    rd_en, wr_en;
    logic [N*AW-1:0] rd_addr, wr_addr;
    logic [N*DW-1:0] wr_data, rd_data;
    logic            collision, error;

    int              checks = 0;
    int              fails  = 0;
    logic [DW-1:0]   mdl [DEPTH];
    int              ptr_m;
    bit              done = 1'b0;

    always #2 clk = ~clk;

    cwrf_shared_regfile #(.NPORTS(N), .DEPTH(DEPTH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .prio_high_i(prio_high),
        .comb_max_i(comb_max), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .collision_o(collision), .error_o(error)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        rd_en = '0; wr_en = '0; rd_addr = '0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic rd(input int p, input int a);
        rd_en[p] = 1'b1; rd_addr[p*AW +: AW] = AW'(a);
    endtask

    task automatic wr(input int p, input int a, input int d);
        wr_en[p] = 1'b1; wr_addr[p*AW +: AW] = AW'(a); wr_data[p*DW +: DW] = DW'(d);
    endtask

    // Check the outputs for the inputs now applied, then advance model and clock.
    task automatic cycle(input string tag);
        logic [DW-1:0] nxt [DEPTH];
        bit            exp_coll, exp_err, excl;
        #1;
        for (int p = 0; p < N; p++)
            chk(rd_data[p*DW +: DW] == mdl[rd_addr[p*AW +: AW]], tag,
                int'(rd_data[p*DW +: DW]), int'(mdl[rd_addr[p*AW +: AW]]));
        excl     = !(mode inside {3'd1, 3'd2, 3'd3, 3'd4});
        exp_coll = 1'b0;
        exp_err  = 1'b0;
        for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
                if (excl && rd_en[i] && rd_en[j] &&
                    rd_addr[i*AW +: AW] == rd_addr[j*AW +: AW]) exp_err = 1'b1;
        for (int c = 0; c < DEPTH; c++) begin
            int            cnt;
            bit            agree;
            logic [DW-1:0] lo, hi, sm, mx, ar, d;
            nxt[c] = mdl[c];
            cnt = 0; agree = 1'b1; lo = '0; hi = '0; sm = '0; mx = '0; ar = '0;
            for (int p = 0; p < N; p++) begin
                if (wr_en[p] && wr_addr[p*AW +: AW] == AW'(c)) begin
                    d = wr_data[p*DW +: DW];
                    if (cnt == 0) lo = d;
                    else if (d != lo) agree = 1'b0;
                    hi = d; sm = sm + d;
                    if (d > mx) mx = d;
                    cnt++;
                end
            end
            for (int k = N - 1; k >= 0; k--) begin
                int q = (ptr_m + k) % N;
                if (wr_en[q] && wr_addr[q*AW +: AW] == AW'(c)) ar = wr_data[q*DW +: DW];
            end
            if (cnt == 1) nxt[c] = lo;
            else if (cnt > 1) begin
                exp_coll = 1'b1;
                case (mode)
                    3'd1: nxt[c] = ar;
                    3'd2: if (agree) nxt[c] = lo; else exp_err = 1'b1;
                    3'd3: nxt[c] = prio_high ? hi : lo;
                    3'd4: nxt[c] = comb_max ? mx : sm;
                    default: exp_err = 1'b1;
                endcase
            end
        end
        chk(collision == exp_coll, {tag, " collision"}, int'(collision), int'(exp_coll));
        chk(error == exp_err, {tag, " error"}, int'(error), int'(exp_err));
        @(posedge clk);
        for (int c = 0; c < DEPTH; c++) mdl[c] = nxt[c];
        if (mode == 3'd1 && exp_coll) ptr_m = (ptr_m + 1) % N;
        @(negedge clk);
        idle();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; mode = 3'd0; prio_high = 1'b0; comb_max = 1'b0;
        idle();
        for (int c = 0; c < DEPTH; c++) mdl[c] = '0;
        ptr_m = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all cells read as zero and flags are low after reset.
        for (int c = 0; c < DEPTH; c += N) begin
            for (int p = 0; p < N; p++) rd_addr[p*AW +: AW] = AW'(c + p);
            cycle("R1");
        end

        // R2: a same-cycle read sees the old value, the next cycle sees the new one.
        wr(0, 3, 8'h11); rd(1, 3); cycle("R2");
        rd(1, 3); cycle("R2");

        // R3: a lone writer succeeds under every policy code.
        for (int m = 0; m < 8; m++) begin
            mode = 3'(m); wr(2, 8 + (m % 8), 8'hA0 + m); cycle("R3");
            rd(0, 8 + (m % 8)); cycle("R3");
        end

        // R4: exclusive read clash, write clash, and an unassigned code.
        mode = 3'd0; rd(0, 5); rd(1, 5); cycle("R4");
        wr(0, 3, 8'h55); wr(2, 3, 8'h66); cycle("R4");
        rd(3, 3); cycle("R4");
        mode = 3'd6; wr(1, 3, 8'h77); wr(3, 3, 8'h77); cycle("R4");
        rd(0, 3); cycle("R4");

        // R5: rotating winner, including a wrap and two colliding cells at once.
        mode = 3'd1;
        wr(1, 7, 8'h01); wr(3, 7, 8'h03); cycle("R5");
        rd(0, 7); wr(0, 7, 8'h10); wr(2, 7, 8'h12); cycle("R5");
        rd(0, 7); wr(0, 7, 8'h20); wr(1, 7, 8'h21); cycle("R5");
        rd(0, 7); wr(0, 6, 8'h30); wr(1, 6, 8'h31);
        wr(2, 9, 8'h32); wr(3, 9, 8'h33); cycle("R5");
        rd(0, 6); rd(1, 9); wr(1, 7, 8'h41); wr(2, 7, 8'h42); cycle("R5");
        rd(0, 7); cycle("R5");

        // R6: common policy, agreeing group then disagreeing group.
        mode = 3'd2; wr(0, 4, 8'h5A); wr(1, 4, 8'h5A); wr(3, 4, 8'h5A); cycle("R6");
        rd(0, 4); wr(1, 4, 8'h01); wr(2, 4, 8'h02); cycle("R6");
        rd(0, 4); cycle("R6");

        // R7: priority, lowest then highest index wins.
        mode = 3'd3; prio_high = 1'b0;
        wr(1, 10, 8'hB1); wr(2, 10, 8'hB2); wr(3, 10, 8'hB3); cycle("R7");
        rd(0, 10); prio_high = 1'b1;
        wr(0, 10, 8'hC0); wr(1, 10, 8'hC1); wr(2, 10, 8'hC2); cycle("R7");
        rd(0, 10); cycle("R7");

        // R8: wrapping sum (F0+20+30 = 140, stored 40).
        mode = 3'd4; comb_max = 1'b0;
        wr(0, 11, 8'hF0); wr(2, 11, 8'h20); wr(3, 11, 8'h30); cycle("R8");
        rd(1, 11); cycle("R8");

        // R9: unsigned maximum, including the top value.
        comb_max = 1'b1;
        wr(0, 12, 8'h7F); wr(1, 12, 8'h80); wr(2, 12, 8'h10); cycle("R9");
        rd(1, 12); wr(0, 12, 8'h00); wr(3, 12, 8'hFF); cycle("R9");
        rd(1, 12); cycle("R9");

        // R10 and R2: random traffic dense in collisions over all policy codes.
        for (int n = 0; n < 4000; n++) begin
            mode      = 3'($urandom_range(0, 5));
            prio_high = 1'($urandom_range(0, 1));
            comb_max  = 1'($urandom_range(0, 1));
            for (int p = 0; p < N; p++) begin
                rd_en[p] = 1'($urandom_range(0, 1));
                rd_addr[p*AW +: AW] = AW'($urandom_range(0, 3));
                if ($urandom_range(0, 3) != 0)
                    wr(p, $urandom_range(0, 3),
                       ($urandom_range(0, 1) != 0) ? $urandom_range(0, 2) : $urandom_range(0, 255));
            end
            cycle("R10");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule